// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block sits beside the program counter in the fetch stage. It keeps a small direct-mapped table of recently seen branches. Each slot holds a valid flag, the upper address bits of the branch as a tag, the branch destination, and a two-bit saturating direction counter.

Every cycle the fetch address is looked up combinationally. The block reports whether a stored branch matches and whether it is expected to be taken. It then offers the address to fetch next: the stored destination on a taken prediction, otherwise the sequential address four bytes on.

When a branch resolves later in the pipeline, the resolution side presents the branch address, its real outcome and destination, and what fetch had predicted for it. The block compares the prediction with the outcome and raises a flush request with the correct restart address when they differ. On the following clock edge it trains or allocates the matching slot.

Top module: `btb_predictor`

## Requirements
- R1: After reset every slot is empty, so no fetch address hits, the taken flag is low, and the next address is the fetch address plus 4.
- R2: A lookup hits only when the slot selected by fetch address bits [IDX_W+1:2] is valid and its stored tag equals address bits [PC_W-1:IDX_W+2]. Two branches that share an index but differ in tag do not hit each other's slot.
- R3: The taken flag is high exactly when the lookup hits and the slot counter is 2 or 3. The next address is then the stored destination; in every other case it is the fetch address plus 4.
- R4: A resolved taken branch that misses allocates its slot with counter value 2 (binary 10) and its destination. The new slot is visible to lookups from the cycle after the update, and not in the update cycle itself.
- R5: A resolved not-taken branch that misses leaves the table unchanged, so a later lookup of that address still misses.
- R6: On an update that hits, the counter increments on taken and decrements on not-taken, saturating at 3 and at 0.
- R7: The predicted direction of a slot changes only after two consecutive outcomes that disagree with it, starting from a saturated counter.
- R8: A taken update that hits replaces the stored destination with the resolved one.
- R9: In the update cycle, the flush output is high exactly when an update is presented and either the resolved direction differs from the predicted one, or both are taken and the destinations differ. The restart address is the resolved destination when taken, else the branch address plus 4.
- R10: Once trained, a loop branch that is taken on every iteration except the last requests a flush only at the loop exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_hit | output | 1 | A valid slot matches the fetch address |
| pred_taken | output | 1 | The matching branch is predicted taken |
| next_pc | output | PC_W | Address to fetch in the next cycle |
| upd_valid | input | 1 | A branch resolution is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_target | input | PC_W | Resolved destination of the branch |
| upd_taken | input | 1 | Resolved direction of the branch |
| upd_pred_taken | input | 1 | Direction fetch predicted for this branch |
| upd_pred_target | input | PC_W | Address fetch followed after this branch |
| mispredict | output | 1 | Flush request for the wrongly fetched path |
| recover_pc | output | PC_W | Correct address to restart fetch from |

## Verification
Lookup results (hit, taken flag, next address) and the flush request with its restart address are combinational. They are due in the same cycle their inputs are applied. Table training becomes visible only to lookups in the cycle after the clock edge that takes the update. The bench applies inputs just after the falling edge and compares all outputs with its reference model shortly before the next rising edge. Only after that comparison does it advance the model's table, so an update is never expected to affect the lookup of its own cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_MIN   = 2'b00;
    localparam ctr_t CTR_MAX   = 2'b11;
    localparam ctr_t CTR_ALLOC = 2'b10;

    function automatic ctr_t ctr_train(ctr_t cur, logic went_taken);
        ctr_t nxt;
        if (went_taken)
            nxt = (cur == CTR_MAX) ? cur : cur + 2'd1;
        else
            nxt = (cur == CTR_MIN) ? cur : cur - 2'd1;
        return nxt;
    endfunction

    function automatic logic ctr_leans_taken(ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 26,
    parameter int PC_W    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] fa_idx,
    output logic             fa_vld,
    output logic [TAG_W-1:0] fa_tag,
    output logic [PC_W-1:0]  fa_dst,
    output ctr_t             fa_ctr,
    input  logic [IDX_W-1:0] ua_idx,
    output logic             ua_vld,
    output logic [TAG_W-1:0] ua_tag,
    output logic [PC_W-1:0]  ua_dst,
    output ctr_t             ua_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_dst,
    input  ctr_t             wr_ctr
);
    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [PC_W-1:0]    dst_q [ENTRIES];
    ctr_t               ctr_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            dst_q[wr_idx] <= wr_dst;
            ctr_q[wr_idx] <= wr_ctr;
        end
    end

    always_comb begin
        fa_vld = vld_q[fa_idx];
        fa_tag = tag_q[fa_idx];
        fa_dst = dst_q[fa_idx];
        fa_ctr = ctr_q[fa_idx];
        ua_vld = vld_q[ua_idx];
        ua_tag = tag_q[ua_idx];
        ua_dst = dst_q[ua_idx];
        ua_ctr = ctr_q[ua_idx];
    end

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
#(
    parameter int TAG_W = 26,
    parameter int PC_W  = 32
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [TAG_W-1:0] pc_tag,
    input  logic             ent_vld,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [PC_W-1:0]  ent_dst,
    input  ctr_t             ent_ctr,
    output logic             hit,
    output logic             taken,
    output logic [PC_W-1:0]  next_pc
);
    always_comb begin
        hit     = ent_vld && (ent_tag == pc_tag);
        taken   = hit && ctr_leans_taken(ent_ctr);
        next_pc = taken ? ent_dst : pc + PC_W'(4);
    end
endmodule

// File: rtl/btb_update.sv
module btb_update
    import btb_pkg::*;
#(
    parameter int TAG_W = 26,
    parameter int PC_W  = 32
) (
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic [PC_W-1:0]  upd_target,
    input  logic             upd_taken,
    input  logic             upd_pred_taken,
    input  logic [PC_W-1:0]  upd_pred_target,
    input  logic             ent_vld,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [PC_W-1:0]  ent_dst,
    input  ctr_t             ent_ctr,
    output logic             wr_en,
    output logic [TAG_W-1:0] wr_tag,
    output logic [PC_W-1:0]  wr_dst,
    output ctr_t             wr_ctr,
    output logic             mispredict,
    output logic [PC_W-1:0]  recover_pc
);
    logic present;

    always_comb begin
        present = ent_vld && (ent_tag == upd_tag);
        wr_tag  = upd_tag;
        wr_en   = 1'b0;
        wr_dst  = ent_dst;
        wr_ctr  = ent_ctr;
        if (upd_valid) begin
            if (present) begin
                wr_en  = 1'b1;
                wr_ctr = ctr_train(ent_ctr, upd_taken);
                wr_dst = upd_taken ? upd_target : ent_dst;
            end else if (upd_taken) begin
                wr_en  = 1'b1;
                wr_ctr = CTR_ALLOC;
                wr_dst = upd_target;
            end
        end
    end

    always_comb begin
        mispredict = upd_valid &&
                     ((upd_taken != upd_pred_taken) ||
                      (upd_taken && (upd_pred_target != upd_target)));
        recover_pc = upd_taken ? upd_target : upd_pc + PC_W'(4);
    end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_taken,
    input  logic            upd_pred_taken,
    input  logic [PC_W-1:0] upd_pred_target,
    output logic            mispredict,
    output logic [PC_W-1:0] recover_pc
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W - 2;

    logic [IDX_W-1:0] f_idx, u_idx, w_idx;
    logic [TAG_W-1:0] f_tag, u_tag;

    logic             fa_vld, ua_vld, wr_en;
    logic [TAG_W-1:0] fa_tag, ua_tag, wr_tag;
    logic [PC_W-1:0]  fa_dst, ua_dst, wr_dst;
    ctr_t             fa_ctr, ua_ctr, wr_ctr;

    assign f_idx = fetch_pc[IDX_W+1:2];
    assign f_tag = fetch_pc[PC_W-1:IDX_W+2];
    assign u_idx = upd_pc[IDX_W+1:2];
    assign u_tag = upd_pc[PC_W-1:IDX_W+2];
    assign w_idx = u_idx;

    btb_store #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .fa_idx(f_idx), .fa_vld(fa_vld), .fa_tag(fa_tag), .fa_dst(fa_dst), .fa_ctr(fa_ctr),
        .ua_idx(u_idx), .ua_vld(ua_vld), .ua_tag(ua_tag), .ua_dst(ua_dst), .ua_ctr(ua_ctr),
        .wr_en(wr_en), .wr_idx(w_idx), .wr_tag(wr_tag), .wr_dst(wr_dst), .wr_ctr(wr_ctr)
    );

    btb_lookup #(.TAG_W(TAG_W), .PC_W(PC_W)) u_lookup (
        .pc(fetch_pc), .pc_tag(f_tag),
        .ent_vld(fa_vld), .ent_tag(fa_tag), .ent_dst(fa_dst), .ent_ctr(fa_ctr),
        .hit(pred_hit), .taken(pred_taken), .next_pc(next_pc)
    );

    btb_update #(.TAG_W(TAG_W), .PC_W(PC_W)) u_update (
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_tag(u_tag),
        .upd_target(upd_target), .upd_taken(upd_taken),
        .upd_pred_taken(upd_pred_taken), .upd_pred_target(upd_pred_target),
        .ent_vld(ua_vld), .ent_tag(ua_tag), .ent_dst(ua_dst), .ent_ctr(ua_ctr),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_dst(wr_dst), .wr_ctr(wr_ctr),
        .mispredict(mispredict), .recover_pc(recover_pc)
    );
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] fetch_pc,
    input logic            pred_hit,
    input logic            pred_taken,
    input logic [PC_W-1:0] next_pc,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic [PC_W-1:0] upd_target,
    input logic            upd_taken,
    input logic            mispredict,
    input logic [PC_W-1:0] recover_pc
);
    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !pred_hit);

    p_taken_needs_hit_r3: assert property (@(posedge clk) disable iff (rst)
        pred_taken |-> pred_hit);

    p_sequential_when_not_taken_r3: assert property (@(posedge clk) disable iff (rst)
        !pred_taken |-> next_pc == fetch_pc + PC_W'(4));

    p_taken_update_hits_next_r4: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && !$isunknown(upd_pc)) |=>
            ((fetch_pc != $past(upd_pc)) || pred_hit));

    p_flush_needs_update_r9: assert property (@(posedge clk) disable iff (rst)
        mispredict |-> upd_valid);

    p_restart_address_r9: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken) |-> recover_pc == upd_target);
endmodule

bind btb_predictor btb_checker #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
    .pred_taken(pred_taken), .next_pc(next_pc), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_target(upd_target), .upd_taken(upd_taken),
    .mispredict(mispredict), .recover_pc(recover_pc)
);

// File: tb/sim_btb_predictor.sv
module sim_btb_predictor;
    localparam int PC_W    = 32;
    localparam int ENTRIES = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            pred_hit, pred_taken, mispredict;
    logic [PC_W-1:0] next_pc, recover_pc;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0, upd_target = '0, upd_pred_target = '0;
    logic            upd_taken = 1'b0, upd_pred_taken = 1'b0;

    always #5 clk = ~clk;

    btb_predictor #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u0 (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
        .pred_taken(pred_taken), .next_pc(next_pc), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_target(upd_target), .upd_taken(upd_taken),
        .upd_pred_taken(upd_pred_taken), .upd_pred_target(upd_pred_target),
        .mispredict(mispredict), .recover_pc(recover_pc)
    );

    // Reference model: one record per slot, keyed by word address
    bit              m_used [ENTRIES];
    logic [PC_W-1:0] m_addr [ENTRIES];
    logic [PC_W-1:0] m_dest [ENTRIES];
    int              m_cnt  [ENTRIES];

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;
    bit  last_flush;

    function automatic int slot_of(logic [PC_W-1:0] a);
        return int'((a >> 2) % ENTRIES);
    endfunction

    function automatic bit m_hit(logic [PC_W-1:0] a);
        int s = slot_of(a);
        return m_used[s] && (m_addr[s][PC_W-1:2] == a[PC_W-1:2]);
    endfunction

    function automatic bit m_taken(logic [PC_W-1:0] a);
        return m_hit(a) && (m_cnt[slot_of(a)] >= 2);
    endfunction

    function automatic logic [PC_W-1:0] m_next(logic [PC_W-1:0] a);
        return m_taken(a) ? m_dest[slot_of(a)] : a + 4;
    endfunction

    task automatic check(string req, string what, logic [PC_W-1:0] got, logic [PC_W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // One cycle: drive after falling edge, compare before rising edge, then train model
    task automatic step(string req, logic [PC_W-1:0] fpc, bit uv,
                        logic [PC_W-1:0] upc, logic [PC_W-1:0] utgt, bit utk);
        bit              p_tk;
        logic [PC_W-1:0] p_dst;
        bit              e_flush;
        logic [PC_W-1:0] e_rec;
        int              s;
        p_tk  = m_taken(upc);
        p_dst = m_next(upc);
        fetch_pc        = fpc;
        upd_valid       = uv;
        upd_pc          = upc;
        upd_target      = utgt;
        upd_taken       = utk;
        upd_pred_taken  = p_tk;
        upd_pred_target = p_dst;
        #3;
        check(req, "pred_hit",   PC_W'(pred_hit),   PC_W'(m_hit(fpc)));
        check(req, "pred_taken", PC_W'(pred_taken), PC_W'(m_taken(fpc)));
        check(req, "next_pc",    next_pc,           m_next(fpc));
        e_flush = uv && ((utk != p_tk) || (utk && p_dst != utgt));
        e_rec   = utk ? utgt : upc + 4;
        check(req, "mispredict", PC_W'(mispredict), PC_W'(e_flush));
        if (uv) check(req, "recover_pc", recover_pc, e_rec);
        last_flush = mispredict;
        @(posedge clk);
        if (uv) begin
            s = slot_of(upc);
            if (m_hit(upc)) begin
                if (utk) begin
                    m_cnt[s]  = (m_cnt[s] < 3) ? m_cnt[s] + 1 : 3;
                    m_dest[s] = utgt;
                end else begin
                    m_cnt[s]  = (m_cnt[s] > 0) ? m_cnt[s] - 1 : 0;
                end
            end else if (utk) begin
                m_used[s] = 1;
                m_addr[s] = upc;
                m_dest[s] = utgt;
                m_cnt[s]  = 2;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [PC_W-1:0] pa, pb, pc_alias, pl;
        int flushes;
        pa = 32'h0000_0104;
        pb = 32'h0000_010C;
        pc_alias = pa + ENTRIES * 4;
        pl = 32'h0000_0248;
        for (int i = 0; i < ENTRIES; i++) m_used[i] = 0;

        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset
        step("R1", pa, 0, 0, 0, 0);
        step("R1", 32'hFFFF_FFFC, 0, 0, 0, 0);

        // R4: allocate taken miss; not visible same cycle
        step("R4", pa, 1, pa, 32'h0000_0400, 1);
        step("R4 R3", pa, 0, 0, 0, 0);

        // R5: not-taken miss allocates nothing
        step("R5", pb, 1, pb, 32'h0000_0800, 0);
        step("R5", pb, 0, 0, 0, 0);

        // R2: alias of pa misses
        step("R2", pc_alias, 0, 0, 0, 0);
        step("R2", pa + 1, 0, 0, 0, 0);

        // R6/R7: saturate high then hysteresis
        step("R6", pa, 1, pa, 32'h0000_0400, 1);
        step("R6", pa, 1, pa, 32'h0000_0400, 1);
        step("R7", pa, 1, pa, 32'h0000_0400, 0);
        step("R7", pa, 1, pa, 32'h0000_0400, 0);
        step("R7", pa, 0, 0, 0, 0);
        step("R6", pa, 1, pa, 32'h0000_0400, 0);
        step("R6", pa, 1, pa, 32'h0000_0400, 0);
        step("R6", pa, 1, pa, 32'h0000_0400, 1);
        step("R6", pa, 1, pa, 32'h0000_0400, 1);
        step("R6 R3", pa, 0, 0, 0, 0);

        // R8: taken hit refreshes destination (also a target mispredict, R9)
        step("R8 R9", pa, 1, pa, 32'h0000_0600, 1);
        step("R8", pa, 0, 0, 0, 0);

        // R9: alias update does not touch pa, taken alias allocates over it
        step("R9", pa, 1, pc_alias, 32'h0000_0A00, 0);
        step("R9 R2", pa, 1, pc_alias, 32'h0000_0A00, 1);
        step("R2", pa, 0, 0, 0, 0);
        step("R2", pc_alias, 0, 0, 0, 0);

        // R10: loop trained on first pass, second pass flushes once
        for (int pass = 0; pass < 3; pass++) begin
            flushes = 0;
            for (int it = 0; it < 5; it++) begin
                step("R10", pl, 1, pl, 32'h0000_01C0, it != 4);
                if (last_flush) flushes++;
            end
            if (pass > 0)
                check("R10", "loop flushes", PC_W'(flushes), PC_W'(1));
        end

        finish_run();
    end
endmodule